// File: doc/BRIEF.md
# Key-Folded Sum-of-Products Instruction Sequencer

This controller drives a word-parallel associative array so that every word evaluates the same sum-of-products function in one pass. It walks a small external table of product terms. Each term gives a mask of cared bit positions and the polarity wanted at each of them. For every term the sequencer broadcasts one ternary MATCH and then one CALC. The CALC copies the hit into the accumulator for the first term and ORs it in for every later term. The round key is applied inside the broadcast pattern itself: every cared bit whose key bit is 1 has its polarity flipped. The array therefore never stores the key and never spends an XOR step on it.

When folding is enabled, the sequencer then emits four more instructions. It shifts the accumulator into the neighbouring word, matches the chosen column there, XORs the two and writes the result back into that column. The sequencer waits for the array to be idle before it issues each instruction. It raises a one-cycle done pulse once the array has finished with the last one.

Top module: `minterm_seq`

## Requirements
- R1: After reset `instValid`, `done` and `instOp` are all 0, and no instruction is issued until `start` is pulsed.
- R2: Term t gives a MATCH (`instOp`=1). Its `instCare` is the term's care mask, where 1 means a compared position. Its `instVal` is `(termVal ^ key) & termCare`: a cared bit is inverted where the key bit is 1, and wildcard positions carry 0.
- R3: Each term is a MATCH followed by a CALC. The CALC for entry 0 is a copy (`instOp`=2), and the CALC for every later entry is an OR into the accumulator (`instOp`=3).
- R4: The term walk stops after the first entry whose last flag is set. It also stops after entry 63 if no entry is flagged, so at most 64 terms are issued.
- R5: When `tableEmpty` is high at start, the term walk is replaced by a single clearing CALC (`instOp`=4).
- R6: With `foldEn` set, four instructions follow the term walk, in this order:
  - SHIFT (`instOp`=6).
  - MATCH with care and value both one-hot at `foldCol`.
  - XOR CALC (`instOp`=5).
  - WRITECOLUMN (`instOp`=7) with `instCol`=`foldCol`.
- R7: An instruction is a one-cycle `instValid` pulse. It is issued only in a cycle that follows a cycle with `arrBusy` low. Two pulses are never adjacent. When the array never stalls, instructions are exactly 2 cycles apart.
- R8: `done` pulses for exactly one cycle, 2 cycles after the final instruction when the array is idle, and later by however long `arrBusy` stays high.
- R9: A `start` pulse during a run is ignored. Key, fold enable and fold column are captured at the accepted start, so later changes to them do not alter the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted only when idle) |
| tableEmpty | input | 1 | The term table has no entries |
| foldEn | input | 1 | Append the fold-into-neighbour steps |
| foldCol | input | 6 | Column written by the fold |
| keyVec | input | 42 | Round key folded into the match patterns |
| termIdx | output | 6 | Table entry being read |
| termCare | input | 42 | Care mask of the addressed entry |
| termVal | input | 42 | Polarity of the addressed entry |
| termLast | input | 1 | Addressed entry is the final term |
| arrBusy | input | 1 | Array is still executing an instruction |
| instValid | output | 1 | Instruction fields are valid this cycle |
| instOp | output | 3 | Instruction opcode |
| instCare | output | 42 | MATCH care mask |
| instVal | output | 42 | MATCH value |
| instCol | output | 6 | WRITECOLUMN target |
| done | output | 1 | Sequence finished (one-cycle pulse) |

## Verification
The bench models the array with a busy counter that stays high for a chosen number of cycles after each instruction. Each instruction must then appear exactly that many cycles plus 2 after the one before it. The done pulse must appear the same distance after the last instruction. A monitor stamps every instruction and every done pulse with a cycle counter on the falling edge. The scenario tasks compare the stamped gaps with the expected gap for the previous opcode: 0 extra cycles when the array never stalls, 4 after a MATCH and 2 otherwise when it does. They also compare the captured sequence, field by field, with one rebuilt from the requirements.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_MATCH     = 3'd1,
    OP_CALC_COPY = 3'd2,
    OP_CALC_OR   = 3'd3,
    OP_CALC_CLR  = 3'd4,
    OP_CALC_XOR  = 3'd5,
    OP_SHIFT     = 3'd6,
    OP_WRCOL     = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    PAT_NONE = 2'd0,
    PAT_TERM = 2'd1,
    PAT_COL  = 2'd2
  } pat_e;

  typedef struct packed {
    logic capture;
    logic issue;
    op_e  op;
    pat_e pat;
    logic idxInc;
    logic doneSet;
  } strobe_t;

endpackage

// File: rtl/mseq_ctrl.sv
module mseq_ctrl
  import mseq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    tableEmpty,
  input  logic    termLast,
  input  logic    idxAtEnd,
  input  logic    firstTerm,
  input  logic    foldEnQ,
  input  logic    arrBusy,
  output strobe_t stb
);

  typedef enum logic [3:0] {
    S_IDLE, S_MATCH, S_CALC, S_CLR, S_SHIFT, S_FMATCH, S_FXOR, S_WRCOL, S_DRAIN
  } state_e;

  state_e state, nxt;
  logic   waitQ;
  logic   go;

  assign go = !waitQ && !arrBusy;

  always_comb begin
    stb = '0;
    nxt = state;
    case (state)
      S_IDLE: if (start) begin
        stb.capture = 1'b1;
        nxt = tableEmpty ? S_CLR : S_MATCH;
      end
      S_MATCH: if (go) begin
        stb.issue = 1'b1;
        stb.op    = OP_MATCH;
        stb.pat   = PAT_TERM;
        nxt       = S_CALC;
      end
      S_CALC: if (go) begin
        stb.issue = 1'b1;
        stb.op    = firstTerm ? OP_CALC_COPY : OP_CALC_OR;
        if (termLast || idxAtEnd) begin
          nxt = foldEnQ ? S_SHIFT : S_DRAIN;
        end else begin
          stb.idxInc = 1'b1;
          nxt = S_MATCH;
        end
      end
      S_CLR: if (go) begin
        stb.issue = 1'b1;
        stb.op    = OP_CALC_CLR;
        nxt       = foldEnQ ? S_SHIFT : S_DRAIN;
      end
      S_SHIFT: if (go) begin
        stb.issue = 1'b1;
        stb.op    = OP_SHIFT;
        nxt       = S_FMATCH;
      end
      S_FMATCH: if (go) begin
        stb.issue = 1'b1;
        stb.op    = OP_MATCH;
        stb.pat   = PAT_COL;
        nxt       = S_FXOR;
      end
      S_FXOR: if (go) begin
        stb.issue = 1'b1;
        stb.op    = OP_CALC_XOR;
        nxt       = S_WRCOL;
      end
      S_WRCOL: if (go) begin
        stb.issue = 1'b1;
        stb.op    = OP_WRCOL;
        nxt       = S_DRAIN;
      end
      S_DRAIN: if (go) begin
        stb.doneSet = 1'b1;
        nxt = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      waitQ <= 1'b0;
    end else begin
      state <= nxt;
      waitQ <= stb.issue;
    end
  end

  // R9: a new capture can only happen from idle, never mid-run
  p_capture_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stb.capture |-> (state == S_IDLE));

endmodule

// File: rtl/mseq_dp.sv
module mseq_dp
  import mseq_pkg::*;
#(
  parameter int WORD_W = 42,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int COL_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              arrBusy,
  input  logic [WORD_W-1:0] keyVec,
  input  logic              foldEn,
  input  logic [COL_W-1:0]  foldCol,
  input  logic [WORD_W-1:0] termCare,
  input  logic [WORD_W-1:0] termVal,
  output logic [IDX_W-1:0]  termIdx,
  output logic              firstTerm,
  output logic              idxAtEnd,
  output logic              foldEnQ,
  output logic              instValid,
  output op_e               instOp,
  output logic [WORD_W-1:0] instCare,
  output logic [WORD_W-1:0] instVal,
  output logic [COL_W-1:0]  instCol,
  output logic              done
);

  logic [IDX_W-1:0]  idxQ;
  logic [WORD_W-1:0] keyQ;
  logic [COL_W-1:0]  foldColQ;
  logic [WORD_W-1:0] colMask;
  logic [WORD_W-1:0] keyedVal;

  for (genvar g = 0; g < WORD_W; g++) begin : g_col
    assign colMask[g] = (foldColQ == COL_W'(g));
  end

  assign keyedVal  = (termVal ^ keyQ) & termCare;
  assign termIdx   = idxQ;
  assign firstTerm = (idxQ == '0);
  assign idxAtEnd  = (idxQ == IDX_W'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      idxQ     <= '0;
      keyQ     <= '0;
      foldColQ <= '0;
      foldEnQ  <= 1'b0;
    end else if (stb.capture) begin
      idxQ     <= '0;
      keyQ     <= keyVec;
      foldColQ <= foldCol;
      foldEnQ  <= foldEn;
    end else if (stb.idxInc) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      instValid <= 1'b0;
      instOp    <= OP_NOP;
      instCare  <= '0;
      instVal   <= '0;
      instCol   <= '0;
      done      <= 1'b0;
    end else begin
      instValid <= stb.issue;
      instOp    <= stb.issue ? stb.op : OP_NOP;
      done      <= stb.doneSet;
      if (stb.issue) begin
        case (stb.pat)
          PAT_TERM: begin instCare <= termCare; instVal <= keyedVal; end
          PAT_COL:  begin instCare <= colMask;  instVal <= colMask;  end
          default:  begin instCare <= '0;       instVal <= '0;       end
        endcase
        instCol <= (stb.op == OP_WRCOL) ? foldColQ : '0;
      end
    end
  end

  p_valid_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    instValid |=> !instValid);

  p_busy_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(instValid) |-> !$past(arrBusy));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !instValid);

  p_or_not_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && instOp == OP_CALC_OR) |-> (idxQ != '0));

  p_idx_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.idxInc |-> !idxAtEnd);

endmodule

// File: rtl/minterm_seq.sv
module minterm_seq
  import mseq_pkg::*;
#(
  parameter int WORD_W = 42,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int COL_W = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              tableEmpty,
  input  logic              foldEn,
  input  logic [COL_W-1:0]  foldCol,
  input  logic [WORD_W-1:0] keyVec,
  output logic [IDX_W-1:0]  termIdx,
  input  logic [WORD_W-1:0] termCare,
  input  logic [WORD_W-1:0] termVal,
  input  logic              termLast,
  input  logic              arrBusy,
  output logic              instValid,
  output logic [2:0]        instOp,
  output logic [WORD_W-1:0] instCare,
  output logic [WORD_W-1:0] instVal,
  output logic [COL_W-1:0]  instCol,
  output logic              done
);

  strobe_t stb;
  logic    firstTerm, idxAtEnd, foldEnQ;
  op_e     opQ;

  mseq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .tableEmpty(tableEmpty),
    .termLast(termLast), .idxAtEnd(idxAtEnd), .firstTerm(firstTerm),
    .foldEnQ(foldEnQ), .arrBusy(arrBusy), .stb(stb)
  );

  mseq_dp #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .arrBusy(arrBusy),
    .keyVec(keyVec), .foldEn(foldEn), .foldCol(foldCol),
    .termCare(termCare), .termVal(termVal), .termIdx(termIdx),
    .firstTerm(firstTerm), .idxAtEnd(idxAtEnd), .foldEnQ(foldEnQ),
    .instValid(instValid), .instOp(opQ), .instCare(instCare),
    .instVal(instVal), .instCol(instCol), .done(done)
  );

  assign instOp = opQ;

endmodule

// File: tb/sim_minterm_seq.sv
module sim_minterm_seq;

  localparam int W = 42;
  localparam int N = 64;
  localparam int MAXI = 200;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          tableEmpty = 1'b0;
  logic          foldEn = 1'b0;
  logic [5:0]    foldCol = '0;
  logic [W-1:0]  keyVec = '0;
  logic [5:0]    termIdx;
  logic [W-1:0]  termCare, termVal;
  logic          termLast;
  logic          arrBusy;
  logic          instValid;
  logic [2:0]    instOp;
  logic [W-1:0]  instCare, instVal;
  logic [5:0]    instCol;
  logic          done;

  logic [W-1:0] tCare [N];
  logic [W-1:0] tVal  [N];
  logic         tLast [N];

  assign termCare = tCare[termIdx];
  assign termVal  = tVal[termIdx];
  assign termLast = tLast[termIdx];

  minterm_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .tableEmpty(tableEmpty),
    .foldEn(foldEn), .foldCol(foldCol), .keyVec(keyVec), .termIdx(termIdx),
    .termCare(termCare), .termVal(termVal), .termLast(termLast),
    .arrBusy(arrBusy), .instValid(instValid), .instOp(instOp),
    .instCare(instCare), .instVal(instVal), .instCol(instCol), .done(done)
  );

  always #5 clk = ~clk;

  // array model: busy for a per-opcode latency after each instruction
  bit stallOn = 0;
  int busyCnt = 0;
  assign arrBusy = (busyCnt != 0);
  always @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else if (instValid) busyCnt <= stallOn ? ((instOp == 3'd1) ? 4 : 2) : 0;
    else if (busyCnt != 0) busyCnt <= busyCnt - 1;
  end

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  int       capN = 0;
  logic [2:0]   capOp   [MAXI];
  logic [W-1:0] capCare [MAXI];
  logic [W-1:0] capVal  [MAXI];
  logic [5:0]   capCol  [MAXI];
  int           capCyc  [MAXI];
  int doneCnt = 0;
  int doneCyc = 0;
  always @(negedge clk) begin
    if (instValid && capN < MAXI) begin
      capOp[capN] = instOp; capCare[capN] = instCare;
      capVal[capN] = instVal; capCol[capN] = instCol;
      capCyc[capN] = cyc; capN = capN + 1;
    end
    if (done) begin doneCnt = doneCnt + 1; doneCyc = cyc; end
  end

  // expected sequence
  int           expN;
  logic [2:0]   expOp   [MAXI];
  logic [W-1:0] expCare [MAXI];
  logic [W-1:0] expVal  [MAXI];
  logic [5:0]   expCol  [MAXI];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic push(input logic [2:0] op, input logic [W-1:0] c,
                      input logic [W-1:0] v, input logic [5:0] col);
    expOp[expN] = op; expCare[expN] = c; expVal[expN] = v; expCol[expN] = col;
    expN = expN + 1;
  endtask

  task automatic build_exp(input bit empty, input bit fold,
                           input logic [W-1:0] key, input logic [5:0] col);
    logic [W-1:0] oneHot;
    expN = 0;
    if (empty) push(3'd4, '0, '0, '0);                // R5
    else begin
      for (int t = 0; t < N; t++) begin
        push(3'd1, tCare[t], (tVal[t] ^ key) & tCare[t], '0);       // R2
        push((t == 0) ? 3'd2 : 3'd3, '0, '0, '0);                   // R3
        if (tLast[t]) break;                                        // R4
      end
    end
    if (fold) begin                                                 // R6
      oneHot = '0; oneHot[col] = 1'b1;
      push(3'd6, '0, '0, '0);
      push(3'd1, oneHot, oneHot, '0);
      push(3'd5, '0, '0, '0);
      push(3'd7, '0, '0, col);
    end
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int lat_of(input logic [2:0] op);
    if (!stallOn) return 0;
    return (op == 3'd1) ? 4 : 2;
  endfunction

  // run one sequence and compare everything it produced
  task automatic run(input string req, input bit empty, input bit fold,
                     input logic [W-1:0] key, input logic [5:0] col, input bit midStart);
    @(negedge clk);
    capN = 0; doneCnt = 0;
    tableEmpty = empty; foldEn = fold; keyVec = key; foldCol = col;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (5) @(negedge clk);
      keyVec = ~key; foldEn = ~fold; foldCol = col + 6'd1; tableEmpty = ~empty;
      start = 1'b1;                                                  // R9
      @(negedge clk);
      start = 1'b0;
    end
    for (int k = 0; k < 3000 && doneCnt == 0; k++) @(negedge clk);
    repeat (20) @(negedge clk);
    build_exp(empty, fold, key, col);
    chk(capN == expN, req, "instruction count", 64'(capN), 64'(expN));
    for (int i = 0; i < expN && i < capN; i++) begin
      chk(capOp[i] == expOp[i] && capCare[i] == expCare[i] &&
          capVal[i] == expVal[i] && capCol[i] == expCol[i], req,
          $sformatf("instr %0d op/val", i), {capOp[i], capVal[i]}, {expOp[i], expVal[i]});
      if (i > 0)  // R7 spacing
        chk(capCyc[i] - capCyc[i-1] == lat_of(capOp[i-1]) + 2, "R7",
            $sformatf("gap before instr %0d", i),
            64'(capCyc[i] - capCyc[i-1]), 64'(lat_of(capOp[i-1]) + 2));
    end
    chk(doneCnt == 1, "R8", "done pulse count", 64'(doneCnt), 64'd1);
    if (capN > 0)
      chk(doneCyc - capCyc[capN-1] == lat_of(capOp[capN-1]) + 2, "R8", "done delay",
          64'(doneCyc - capCyc[capN-1]), 64'(lat_of(capOp[capN-1]) + 2));
    foldEn = 1'b0; tableEmpty = 1'b0;
  endtask

  task automatic fill(input int cnt, input int lastAt);
    for (int t = 0; t < N; t++) begin
      tCare[t] = {10'(t * 7 + 3), 32'(t * 32'h9E37_79B9)} | 42'h1;
      tVal[t]  = {10'(t * 5), 32'(32'hA5A5_0000 ^ (t * 32'h0101_1357))};
      tLast[t] = (t == lastAt);
    end
    if (cnt < 0) for (int t = 0; t < N; t++) tLast[t] = 1'b0;
  endtask

  task automatic test_reset;
    chk(instValid == 1'b0 && done == 1'b0 && instOp == 3'd0, "R1", "reset outputs",
        {instValid, done, instOp}, 64'd0);
    repeat (4) @(negedge clk);
    chk(capN == 0, "R1", "no issue without start", 64'(capN), 64'd0);
  endtask

  task automatic test_single;   // R2 R3
    fill(1, 0);
    run("R2", 0, 0, 42'h0, 6'd0, 0);
  endtask

  task automatic test_keyed;    // R2 key fold, R3 copy then OR, R4 last flag
    fill(4, 2);
    run("R3", 0, 0, 42'h2AB_CDEF_0123, 6'd0, 0);
  endtask

  task automatic test_fold;     // R6
    fill(2, 1);
    run("R6", 0, 1, 42'h155_5555_5555, 6'd37, 0);
  endtask

  task automatic test_empty;    // R5
    fill(1, 0);
    run("R5", 1, 0, 42'h3FF_FFFF_FFFF, 6'd0, 0);
    run("R5", 1, 1, 42'h0, 6'd3, 0);
  endtask

  task automatic test_full;     // R4 stop at entry 63
    fill(-1, -1);
    run("R4", 0, 0, 42'h0F0_F0F0_F0F0, 6'd0, 0);
  endtask

  task automatic test_stall;    // R7 R8 with array latency
    stallOn = 1;
    fill(3, 2);
    run("R7", 0, 1, 42'h123_4567_89AB, 6'd41, 0);
    stallOn = 0;
  endtask

  task automatic test_midstart; // R9
    stallOn = 1;
    fill(3, 2);
    run("R9", 0, 1, 42'h0AA_55AA_55AA, 6'd10, 1);
    stallOn = 0;
  endtask

  initial begin
    fill(1, 0);
    repeat (3) @(negedge clk);
    test_reset;
    rstN = 1'b1;
    @(negedge clk);
    test_single;
    test_keyed;
    test_fold;
    test_empty;
    test_full;
    test_stall;
    test_midstart;
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule